// File: doc/BRIEF.md
# Sequential Channel Power Sequencer

This block drives one group of sixteen recording channels that share a single analog-to-digital converter through a 16-to-1 multiplexer. It divides time into fixed conversion slots. Each slot belongs to one channel, in ascending order, and channel 15 is followed by channel 0. At the first clock of a slot the block pulses a start request to the converter. When the converter reports completion, the block returns the sample tagged with the index of the channel it came from.

The preamplifiers stay on all the time. Only the buffers that drive the multiplexer are switched. Exactly two buffers are on at any moment: the channel being converted and the one after it. That window moves forward one clock before the multiplexer select changes, so each buffer has a full slot to settle before it is sampled.

The converter resolution is chosen from 6 to 9 bits. The block passes the setting straight to the converter and left-aligns the returned code into a 9-bit sample. After reset the first two buffers come on at once, and conversions begin only after a programmable settle delay.

Top module: `chan_power_seq`

## Requirements
- R1: At every start pulse the buffers of the selected channel k and of channel k+1 (mod 16) are both enabled.
- R2: Exactly two bits of `buf_en` are set in every cycle, including during reset and settle.
- R3: In the last clock of a slot for channel k, `buf_en` already enables channels k+1 and k+2 (mod 16) while `mux_sel` still shows k. `mux_sel` moves to k+1 on the following clock.
- R4: Channel indices wrap: the slot of channel 15 enables channels 15 and 0, and the next slot selects channel 0.
- R5: Each slot lasts `SLOT_CYCLES` clocks, and `conv_start` is high for exactly the first clock of every slot.
- R6: While reset is held and during the settle phase, `mux_sel` is 0, `buf_en` enables channels 0 and 1 only, and `conv_start` is low. The first `conv_start` is seen in the cycle after `settle_cycles`+1 rising edges following reset release.
- R7: One clock after an accepted `conv_done`, `sample_valid` is high for one clock, and `sample_chan` carries the channel that was selected at the matching start pulse.
- R8: `res_sel` values 0, 1, 2 and 3 select 6, 7, 8 and 9 bits. The low resolution bits of `conv_data` are placed in the top of `sample_data`. The bits below them are zero, and bits of `conv_data` above the resolution are ignored.
- R9: A `conv_done` with no outstanding start is ignored and produces no `sample_valid`.
- R10: `adc_res` always equals `res_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| settle_cycles | input | SETTLE_W | Extra clocks to wait after reset before the first conversion |
| res_sel | input | 2 | Resolution code (0..3 means 6..9 bits) |
| conv_done | input | 1 | Converter completion strobe |
| conv_data | input | SAMPLE_W | Right-aligned converter code |
| conv_start | output | 1 | Start-of-conversion pulse |
| adc_res | output | 2 | Resolution passed to the converter |
| mux_sel | output | CH_W | Channel routed to the converter |
| buf_en | output | NCH | Buffer power enables, one per channel |
| sample_valid | output | 1 | Sample strobe |
| sample_data | output | SAMPLE_W | Left-aligned sample |
| sample_chan | output | CH_W | Channel tag of the sample |

## Verification
The sequencer runs over several full rounds of the sixteen channels, so every slot boundary and the 15-to-0 wrap are compared clock by clock against a reference computed from the slot arithmetic. Three settle delays (zero, short and long) separate an off-by-one in the start of the first conversion from a correct one. The resolution code cycles through all four values with converter codes that carry junk above the resolution, which exposes alignment and masking faults. Stray completion strobes injected between conversions show whether unrequested results leak out as samples.

// File: rtl/chan_power_seq.sv
module chan_power_seq #(
  parameter int NCH         = 16,
  parameter int SAMPLE_W    = 9,
  parameter int RES_MIN     = 6,
  parameter int SLOT_CYCLES = 32,
  parameter int SETTLE_W    = 8,
  localparam int CH_W   = $clog2(NCH),
  localparam int SLOT_W = $clog2(SLOT_CYCLES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic [1:0]          res_sel,
  input  logic                conv_done,
  input  logic [SAMPLE_W-1:0] conv_data,
  output logic                conv_start,
  output logic [1:0]          adc_res,
  output logic [CH_W-1:0]     mux_sel,
  output logic [NCH-1:0]      buf_en,
  output logic                sample_valid,
  output logic [SAMPLE_W-1:0] sample_data,
  output logic [CH_W-1:0]     sample_chan
);

  function automatic logic [CH_W-1:0] step(input logic [CH_W-1:0] c);
    return (c == CH_W'(NCH - 1)) ? '0 : c + 1'b1;
  endfunction

  logic                running, busy;
  logic [SETTLE_W-1:0] settle_cnt;
  logic [SLOT_W-1:0]   slot_cnt;
  logic [CH_W-1:0]     cur_ch, win_lo, tag_ch;
  logic [SAMPLE_W-1:0] aligned;

  wire last_clk = slot_cnt == SLOT_W'(SLOT_CYCLES - 1);
  wire pre_last = slot_cnt == SLOT_W'(SLOT_CYCLES - 2);

  assign conv_start = running && slot_cnt == '0;
  assign mux_sel    = cur_ch;
  assign adc_res    = res_sel;

  always_comb begin
    buf_en = '0;
    buf_en[win_lo] = 1'b1;
    buf_en[step(win_lo)] = 1'b1;
  end

  always_comb begin
    int bits;
    logic [SAMPLE_W-1:0] ones;
    bits = RES_MIN + int'(res_sel);
    if (bits > SAMPLE_W) bits = SAMPLE_W;
    ones = '1;
    aligned = (conv_data & (ones >> (SAMPLE_W - bits))) << (SAMPLE_W - bits);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running    <= 1'b0;
      settle_cnt <= '0;
      slot_cnt   <= '0;
      cur_ch     <= '0;
      win_lo     <= '0;
    end else if (!running) begin
      if (settle_cnt == settle_cycles) running <= 1'b1;
      else settle_cnt <= settle_cnt + 1'b1;
    end else begin
      slot_cnt <= last_clk ? '0 : slot_cnt + 1'b1;
      if (last_clk) cur_ch <= step(cur_ch);
      if (pre_last) win_lo <= step(win_lo);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      tag_ch       <= '0;
      sample_valid <= 1'b0;
      sample_data  <= '0;
      sample_chan  <= '0;
    end else begin
      sample_valid <= conv_done && busy;
      if (conv_done && busy) begin
        sample_data <= aligned;
        sample_chan <= tag_ch;
        busy        <= 1'b0;
      end
      if (conv_start) begin
        busy   <= 1'b1;
        tag_ch <= cur_ch;
      end
    end
  end

  assert_window_at_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (buf_en[mux_sel] && buf_en[step(mux_sel)]));

  assert_two_enables_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(buf_en) == 2);

  assert_enable_leads_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mux_sel) |-> ($past(buf_en) & (NCH'(1) << mux_sel)) != '0);

  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && mux_sel == CH_W'(NCH - 1)) |-> buf_en[0]);

  assert_single_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  assert_sample_follows_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> $past(conv_done));

endmodule

// File: tb/chan_power_seq_tb.sv
module chan_power_seq_tb;
  localparam int NCH = 16, SW = 9, SLOT = 32, LAT = 5;

  logic clk = 0, rst_n = 0;
  logic [7:0] settle_cycles = 0;
  logic [1:0] res_sel = 0;
  logic conv_done = 0;
  logic [SW-1:0] conv_data = 0;
  logic conv_start, sample_valid;
  logic [1:0] adc_res;
  logic [3:0] mux_sel, sample_chan;
  logic [NCH-1:0] buf_en;
  logic [SW-1:0] sample_data;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  chan_power_seq #(.NCH(NCH), .SAMPLE_W(SW), .SLOT_CYCLES(SLOT)) u_dut (
    .clk(clk), .rst_n(rst_n), .settle_cycles(settle_cycles), .res_sel(res_sel),
    .conv_done(conv_done), .conv_data(conv_data), .conv_start(conv_start),
    .adc_res(adc_res), .mux_sel(mux_sel), .buf_en(buf_en),
    .sample_valid(sample_valid), .sample_data(sample_data), .sample_chan(sample_chan));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] win(input int a);
    return (16'(1) << (a % NCH)) | (16'(1) << ((a + 1) % NCH));
  endfunction

  function automatic logic [SW-1:0] align(input logic [SW-1:0] d, input int r);
    int bits = 6 + r;
    int v = int'(d) % (1 << bits);
    return SW'(v * (1 << (SW - bits)));
  endfunction

  task automatic run(input int settle, input int cycles, input bit strays);
    int t = 0, countdown = -1, tag = 0;
    bit outstanding = 0, exp_valid = 0;
    logic [SW-1:0] exp_data = 0;
    int exp_chan = 0;
    rst_n = 0; conv_done = 0; settle_cycles = 8'(settle);
    repeat (3) @(negedge clk);
    chk(mux_sel == 0 && buf_en == 16'h3 && !conv_start && !sample_valid, "R6 reset", {buf_en, 12'(mux_sel), 4'(conv_start)}, 32'h0003_0000);
    rst_n = 1;
    for (int i = 0; i < cycles; i++) begin
      bit run_now, done_now;
      int s, pos;
      @(negedge clk);
      t++;
      run_now = t >= settle + 1;
      s   = run_now ? (t - settle - 1) / SLOT : 0;
      pos = run_now ? (t - settle - 1) % SLOT : -1;
      if (!run_now) begin
        chk(mux_sel == 0 && buf_en == 16'h3, "R6 settle", {buf_en, 12'(mux_sel)}, 32'h0003_0000);
        chk(conv_start == 0, "R6 no start", 32'(conv_start), 0);
      end else begin
        chk(conv_start == (pos == 0), "R5 start pulse", 32'(conv_start), 32'(pos == 0));
        chk(mux_sel == 4'(s % NCH), (s % NCH == 0 && s > 0) ? "R4 wrap select" : "R1 select", 32'(mux_sel), 32'(s % NCH));
        if (pos == SLOT - 1)
          chk(buf_en == win(s + 1), "R3 early window", 32'(buf_en), 32'(win(s + 1)));
        else
          chk(buf_en == win(s), (s % NCH == 15) ? "R4 wrap window" : "R1 window", 32'(buf_en), 32'(win(s)));
      end
      chk($countones(buf_en) == 2, "R2 two enables", 32'(buf_en), 0);
      chk(adc_res == res_sel, "R10 resolution", 32'(adc_res), 32'(res_sel));
      chk(sample_valid == exp_valid, exp_valid ? "R7 valid" : "R9 no sample", 32'(sample_valid), 32'(exp_valid));
      if (exp_valid && sample_valid) begin
        chk(sample_chan == 4'(exp_chan), "R7 tag", 32'(sample_chan), 32'(exp_chan));
        chk(sample_data == exp_data, "R8 align", 32'(sample_data), 32'(exp_data));
      end
      exp_valid = 0;
      done_now = 0;
      conv_done = 0;
      if (countdown > 0) countdown--;
      if (countdown == 0) begin
        done_now = 1; countdown = -1;
      end else if (strays && !outstanding && (t % 7) == 3) begin
        done_now = 1;
      end
      if (done_now) begin
        conv_done = 1;
        conv_data = SW'($urandom);
        exp_valid = outstanding;
        exp_data  = align(conv_data, int'(res_sel));
        exp_chan  = tag;
        outstanding = 0;
      end else if (run_now && pos == SLOT - 2) begin
        res_sel = 2'((s / 3) % 4);
      end
      if (conv_start) begin
        outstanding = 1; countdown = LAT; tag = s % NCH;
      end
    end
  endtask

  initial begin
    run(5, 40 * SLOT, 1);
    run(0, 20 * SLOT, 0);
    run(200, 18 * SLOT + 220, 1);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule